// File: doc/BRIEF.md
# Period-Match Timer with Pre/Postscaler

This block is an up-counter whose period is set by a writable period register rather than by the counter's width. An input clock prescaler (divide by 1, 4 or 16) decides how often the counter advances. Each time the counter already equals the period value when an advance is due, it returns to zero instead. That wrap event is sent out as a one-cycle tick, which can serve as a bit-rate clock for a synchronous serial port. The wrap also drives a postscaler, which divides by any value from 1 to 16.

Each terminal count of the postscaler sets a sticky interrupt flag. The flag reaches the interrupt output only while interrupt enable is set. Software reaches the counter, period, control and status registers over a small single-cycle register bus. A write to the counter or to the control register clears both scaler counts, so a new setting always starts from a clean phase.

Top module: `period_timer`

## Requirements
- R1: On each prescaler pulse the counter increments, unless it already equals the period register, in which case it becomes 0. `matchTick` is high for exactly the one cycle after a wrap, which is the cycle in which the counter reads 0.
- R2: After reset the counter reads 00h, the period reads FFh, the control register reads 00h, the status register reads 00h, `irqOut` is 0 and `matchTick` is 0.
- R3: Control bits 1:0 select the prescaler. 00 gives a pulse on every enabled clock, 01 gives one every 4th and 1x gives one every 16th. After a scaler clear, the first pulse comes on the Nth enabled clock edge.
- R4: Control bits 6:3 hold a value P. The interrupt flag is set on every (P+1)th wrap counted from a scaler clear, so P=0 gives 1:1 and P=15 gives 1:16.
- R5: Control bit 2 is the run enable. While it is 0 the counter holds its value and no prescaler pulses occur.
- R6: `irqOut` is the interrupt flag (status bit 0) ANDed with interrupt enable (status bit 1).
- R7: A write to the counter (address 0) or to control (address 2) clears both the prescaler and postscaler counts, and no prescaler pulse occurs in that cycle.
- R8: A counter write loads the written value. It takes priority over an increment in the same cycle.
- R9: Bus addresses are 0 counter, 1 period, 2 control, 3 status. Reads are combinational. Counter and period read back what was written, and control bit 7 always reads 0.
- R10: A status write loads interrupt enable from bit 1. Writing 0 to bit 0 clears the flag and writing 1 there has no effect. A flag set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr |
| irqOut | output | 1 | Gated interrupt request |
| matchTick | output | 1 | One-cycle wrap pulse (bit-rate tick) |

## Verification
The bench counts clock edges to the exact cycle of each prescaler pulse at all three ratios, including both encodings of the divide-by-16 setting. An off-by-one prescaler, or a decoder that ignores the low select bit, would move the count by a whole step. It sets up postscalers of 1:3 and 1:16 and looks for the flag exactly on the final wrap. A terminal compare against the wrong value would raise the flag one wrap early or late. It writes the counter and the control register mid-period and checks that the next pulse and the next flag are delayed by a full ratio. A design that does not clear the scalers would deliver them early. A design that lets the increment win over the load would read back the written value plus one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRE_W  = 4;
  localparam int POST_W = 4;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_PER  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef struct packed {
    logic              clrScalers;
    logic              loadCnt;
    logic              runEn;
    logic [1:0]        preSel;
    logic [POST_W-1:0] postSel;
  } tmr_strobe_t;

  function automatic logic [PRE_W-1:0] preLast(input logic [1:0] sel);
    case (sel)
      2'b00:   preLast = 4'd0;
      2'b01:   preLast = 4'd3;
      default: preLast = 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CntW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  tmr_strobe_t     stb,
  input  logic [CntW-1:0] loadVal,
  input  logic [CntW-1:0] period,
  output logic [CntW-1:0] cnt,
  output logic            postEvent,
  output logic            matchTick
);
  logic [PRE_W-1:0]  preCnt;
  logic [POST_W-1:0] postCnt;
  logic              prePulse;
  logic              wrap;
  logic              postTerm;

  assign prePulse  = stb.runEn && !stb.clrScalers && (preCnt == preLast(stb.preSel));
  assign wrap      = prePulse && (cnt == period);
  assign postTerm  = (postCnt == stb.postSel);
  assign postEvent = wrap && postTerm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (stb.clrScalers) begin
      preCnt <= '0;
    end else if (stb.runEn) begin
      preCnt <= prePulse ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.loadCnt) begin
      cnt <= loadVal;
    end else if (prePulse) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      postCnt <= '0;
    end else if (stb.clrScalers) begin
      postCnt <= '0;
    end else if (wrap) begin
      postCnt <= postTerm ? '0 : postCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) matchTick <= 1'b0;
    else       matchTick <= wrap;
  end
endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
#(
  parameter int CntW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      busAddr,
  input  logic            busWrEn,
  input  logic [CntW-1:0] busWrData,
  input  logic [CntW-1:0] cnt,
  input  logic            postEvent,
  output tmr_strobe_t     stb,
  output logic [CntW-1:0] period,
  output logic [CntW-1:0] busRdData,
  output logic            irqFlag,
  output logic            irqEn
);
  localparam int CtrlW = POST_W + 3;

  logic [CtrlW-1:0] ctrlReg;
  logic             wrCnt, wrPer, wrCtrl, wrStat;

  assign wrCnt  = busWrEn && (busAddr == ADDR_CNT);
  assign wrPer  = busWrEn && (busAddr == ADDR_PER);
  assign wrCtrl = busWrEn && (busAddr == ADDR_CTRL);
  assign wrStat = busWrEn && (busAddr == ADDR_STAT);

  always_comb begin
    stb.clrScalers = wrCnt || wrCtrl;
    stb.loadCnt    = wrCnt;
    stb.runEn      = ctrlReg[2];
    stb.preSel     = ctrlReg[1:0];
    stb.postSel    = ctrlReg[CtrlW-1:3];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      period  <= '1;
      irqEn   <= 1'b0;
    end else begin
      if (wrCtrl) ctrlReg <= busWrData[CtrlW-1:0];
      if (wrPer)  period  <= busWrData;
      if (wrStat) irqEn   <= busWrData[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       irqFlag <= 1'b0;
    else if (postEvent)              irqFlag <= 1'b1;
    else if (wrStat && !busWrData[0]) irqFlag <= 1'b0;
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_CNT:  busRdData = cnt;
      ADDR_PER:  busRdData = period;
      ADDR_CTRL: busRdData[CtrlW-1:0] = ctrlReg;
      default:   busRdData[1:0] = {irqEn, irqFlag};
    endcase
  end
endmodule

// File: rtl/period_timer.sv
module period_timer
  import tmr_pkg::*;
#(
  parameter int CntW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      busAddr,
  input  logic            busWrEn,
  input  logic [CntW-1:0] busWrData,
  output logic [CntW-1:0] busRdData,
  output logic            irqOut,
  output logic            matchTick
);
  tmr_strobe_t     stb;
  logic [CntW-1:0] period;
  logic [CntW-1:0] cntVal;
  logic            postEvent;
  logic            irqFlag;
  logic            irqEn;

  tmr_control #(.CntW(CntW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .cnt(cntVal), .postEvent(postEvent),
    .stb(stb), .period(period), .busRdData(busRdData),
    .irqFlag(irqFlag), .irqEn(irqEn)
  );

  tmr_datapath #(.CntW(CntW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(busWrData),
    .period(period), .cnt(cntVal), .postEvent(postEvent),
    .matchTick(matchTick)
  );

  assign irqOut = irqFlag && irqEn;
endmodule

// File: rtl/period_timer_chk.sv
module period_timer_chk #(
  parameter int CntW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      busAddr,
  input logic            busWrEn,
  input logic [CntW-1:0] busWrData,
  input logic [CntW-1:0] cntVal,
  input logic            runEn,
  input logic            irqFlag,
  input logic            irqEn,
  input logic            irqOut,
  input logic            matchTick
);
  logic cntWr;
  assign cntWr = busWrEn && (busAddr == 2'd0);

  p_wrap_to_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    matchTick |-> (cntVal == '0));

  p_flag_on_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> matchTick);

  p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cntWr) |=> $stable(cntVal));

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqFlag && irqEn));

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (cntVal == $past(busWrData)));

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !(busWrEn && busAddr == 2'd3 && !busWrData[0])) |=> irqFlag);
endmodule

bind period_timer period_timer_chk #(.CntW(CntW)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .cntVal(cntVal), .runEn(stb.runEn),
  .irqFlag(irqFlag), .irqEn(irqEn), .irqOut(irqOut), .matchTick(matchTick)
);

// File: tb/period_timer_tb.sv
`timescale 1ns/1ps
module period_timer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic       irqOut;
  logic       matchTick;
  int         nChecks = 0;
  int         nErrors = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  period_timer u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut), .matchTick(matchTick)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic chkCnt(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(2'd0, v);
    chk(req, v, exp);
  endtask

  task automatic chkFlag(input string req, input logic exp);
    logic [7:0] v;
    rd(2'd3, v);
    chk(req, {7'd0, v[0]}, {7'd0, exp});
  endtask

  task automatic testReset;
    logic [7:0] v;
    rd(2'd0, v); chk("R2 counter", v, 8'h00);
    rd(2'd1, v); chk("R2 period", v, 8'hFF);
    rd(2'd2, v); chk("R2 control", v, 8'h00);
    rd(2'd3, v); chk("R2 status", v, 8'h00);
    chk("R2 irqOut", {7'd0, irqOut}, 8'h00);
    chk("R2 matchTick", {7'd0, matchTick}, 8'h00);
  endtask

  task automatic testRegs;
    logic [7:0] v;
    wr(2'd1, 8'h37); rd(2'd1, v); chk("R9 period readback", v, 8'h37);
    wr(2'd0, 8'h5A); rd(2'd0, v); chk("R9 counter readback", v, 8'h5A);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R9 control bit7 zero", v, 8'h7F);
    wr(2'd2, 8'h00);
  endtask

  task automatic testWrap;
    wr(2'd2, 8'h00); wr(2'd1, 8'h03); wr(2'd0, 8'h00); wr(2'd3, 8'h00);
    wr(2'd2, 8'h04);
    step(3);
    chkCnt("R1 reaches period", 8'h03);
    chk("R1 no tick before wrap", {7'd0, matchTick}, 8'h00);
    step(1);
    chkCnt("R1 wraps to zero", 8'h00);
    chk("R1 tick on wrap", {7'd0, matchTick}, 8'h01);
    chkFlag("R4 1:1 flag", 1'b1);
    step(1);
    chkCnt("R1 counts after wrap", 8'h01);
    chk("R1 tick one cycle", {7'd0, matchTick}, 8'h00);
  endtask

  task automatic testPrescale;
    wr(2'd2, 8'h00); wr(2'd1, 8'hFF); wr(2'd0, 8'h00);
    wr(2'd2, 8'h05);
    step(3); chkCnt("R3 div4 before", 8'h00);
    step(1); chkCnt("R3 div4 first", 8'h01);
    step(4); chkCnt("R3 div4 second", 8'h02);
    wr(2'd2, 8'h00); wr(2'd0, 8'h00);
    wr(2'd2, 8'h06);
    step(15); chkCnt("R3 div16 sel10 before", 8'h00);
    step(1);  chkCnt("R3 div16 sel10 first", 8'h01);
    wr(2'd2, 8'h07);
    step(15); chkCnt("R3 div16 sel11 before", 8'h01);
    step(1);  chkCnt("R3 div16 sel11 first", 8'h02);
  endtask

  task automatic testHold;
    wr(2'd2, 8'h00); wr(2'd0, 8'h40);
    step(10); chkCnt("R5 holds when off", 8'h40);
    wr(2'd2, 8'h04);
    step(2); chkCnt("R5 resumes", 8'h42);
  endtask

  task automatic testLoad;
    wr(2'd2, 8'h04);
    wr(2'd0, 8'h20); chkCnt("R8 load beats increment", 8'h20);
    step(1); chkCnt("R8 counts from load", 8'h21);
    wr(2'd2, 8'h05);
    step(2);
    wr(2'd0, 8'h10); chkCnt("R7 counter write loads", 8'h10);
    step(3); chkCnt("R7 prescaler cleared", 8'h10);
    step(1); chkCnt("R7 full ratio after clear", 8'h11);
  endtask

  task automatic testPostscale;
    wr(2'd2, 8'h00); wr(2'd1, 8'h01); wr(2'd0, 8'h00); wr(2'd3, 8'h00);
    wr(2'd2, 8'h14);
    step(5); chkFlag("R4 1:3 before", 1'b0);
    step(1); chkFlag("R4 1:3 on third wrap", 1'b1);
    wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd3, 8'h00);
    wr(2'd2, 8'h14);
    step(4);
    wr(2'd2, 8'h14);
    step(5); chkFlag("R7 control write clears postscaler", 1'b0);
    step(1); chkFlag("R7 flag after full count", 1'b1);
    wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h00); wr(2'd3, 8'h00);
    wr(2'd2, 8'h7C);
    step(15); chkFlag("R4 1:16 before", 1'b0);
    step(1);  chkFlag("R4 1:16 on sixteenth wrap", 1'b1);
  endtask

  task automatic testIrq;
    wr(2'd2, 8'h00);
    chkFlag("R10 flag sticky", 1'b1);
    chk("R6 irq masked", {7'd0, irqOut}, 8'h00);
    wr(2'd3, 8'h03);
    chkFlag("R10 write one keeps flag", 1'b1);
    chk("R6 irq enabled", {7'd0, irqOut}, 8'h01);
    wr(2'd3, 8'h02);
    chkFlag("R10 write zero clears", 1'b0);
    chk("R6 irq drops with flag", {7'd0, irqOut}, 8'h00);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    testReset();
    testRegs();
    testWrap();
    testPrescale();
    testHold();
    testLoad();
    testPostscale();
    testIrq();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule